// File: doc/BRIEF.md
# Compare Match Output Pin Unit

This block keeps the compare-output state bit of one timer channel and decides what a shared I/O pin shows. Timer events come in as single-cycle strobes: a compare match, a forced compare, a BOTTOM event, and the count direction. A 2-bit output-action field and a waveform class decide how each strobe changes the state bit. The waveform class is non-PWM, fast PWM or phase-correct PWM.

If the action field is non-zero, the pin takes its data from the state bit. If the field is zero, the pin takes its data from the port data bit. The pin output enable always comes from the port direction bit. Software can therefore preset the state bit with a forced compare while the pin is still an input, and then turn the pin into an output.

Top module: `cmp_pin_unit`

## Requirements
- R1: While rst_ni is low, the state bit is 0. With act_mode_i = 11 and port_dir_i = 1, pin_o reads 0.
- R2: With act_mode_i = 00, no strobe changes the state bit in any waveform class.
- R3: With wave_cls_i = 00 (non-PWM), a match_i pulse updates the state bit on the next clock edge. Mode 01 toggles it, 10 clears it and 11 sets it.
- R4: In the non-PWM class, force_i applies the same action as a match, on the next clock edge.
- R5: When wave_cls_i is not 00, force_i has no effect on the state bit.
- R6: With wave_cls_i = 01 (fast PWM), mode 10 clears the bit on a match and sets it on bottom_i. Mode 11 does the opposite. Mode 01 does nothing.
- R7: With wave_cls_i = 10 (phase-correct), mode 10 clears the bit on a match while count_down_i = 0 and sets it on a match while count_down_i = 1. Mode 11 does the opposite. Mode 01 does nothing.
- R8: pin_o equals the state bit when act_mode_i is not 00. Otherwise pin_o equals port_data_i.
- R9: pin_oe_o always equals port_dir_i, whatever the action field holds.
- R10: In fast PWM, when match_i and bottom_i arrive in the same cycle, the match action wins. The class code 11 is reserved and leaves the state bit unchanged.
- R11: A forced compare made while port_dir_i = 0 presets the state bit, with pin_oe_o kept at 0. The preset value appears on pin_o when port_dir_i goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| match_i | input | 1 | Compare-match pulse |
| force_i | input | 1 | Forced-compare strobe |
| bottom_i | input | 1 | Counter reached BOTTOM (fast PWM) |
| count_down_i | input | 1 | Counter is counting down (phase-correct) |
| act_mode_i | input | 2 | Output-action field |
| wave_cls_i | input | 2 | Waveform class: 00 non-PWM, 01 fast, 10 phase-correct, 11 reserved |
| port_data_i | input | 1 | Port data bit |
| port_dir_i | input | 1 | Port direction bit, 1 = output |
| pin_o | output | 1 | Pin data |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
The bench runs each waveform class through every action code with isolated match, force and BOTTOM strobes. It also covers coincident match and BOTTOM, and matches in both count directions. These runs separate toggle from set from clear, and show which strobes each class responds to.

Switching act_mode_i between 00 and a non-zero value, with no strobe, shows whether mode 00 really froze the state bit. It also shows whether the pin mux follows port data. The preset-while-input sequence shows that direction and data select stay independent.

// File: rtl/cmp_pin_pkg.sv
package cmp_pin_pkg;
  localparam int unsigned MODE_W = 2;
  localparam int unsigned CLS_W  = 2;

  typedef enum logic [CLS_W-1:0] {
    WAVE_NON_PWM = 2'b00,
    WAVE_FAST    = 2'b01,
    WAVE_PHASE   = 2'b10,
    WAVE_RSVD    = 2'b11
  } wave_cls_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } oc_act_e;
endpackage

// File: rtl/oc_event_dec.sv
module oc_event_dec
  import cmp_pin_pkg::*;
(
  input  logic              match_i,
  input  logic              force_i,
  input  logic              bottom_i,
  input  logic              count_down_i,
  input  logic [MODE_W-1:0] act_mode_i,
  input  logic [CLS_W-1:0]  wave_cls_i,
  output oc_act_e           act_o
);
  // PWM classes use only codes 10 and 11; code 01 there is no action
  logic pwm_inv;
  assign pwm_inv = act_mode_i[0];

  always_comb begin
    act_o = ACT_HOLD;
    unique case (wave_cls_i)
      WAVE_NON_PWM: begin
        if (match_i || force_i) act_o = oc_act_e'(act_mode_i);
      end
      WAVE_FAST: begin
        if (act_mode_i[1]) begin
          if (match_i)       act_o = pwm_inv ? ACT_SET : ACT_CLEAR;
          else if (bottom_i) act_o = pwm_inv ? ACT_CLEAR : ACT_SET;
        end
      end
      WAVE_PHASE: begin
        if (act_mode_i[1] && match_i)
          act_o = (pwm_inv ^ count_down_i) ? ACT_SET : ACT_CLEAR;
      end
      default: act_o = ACT_HOLD;
    endcase
  end
endmodule

// File: rtl/oc_state_reg.sv
module oc_state_reg
  import cmp_pin_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  oc_act_e act_i,
  output logic    oc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oc_o <= 1'b0;
    else begin
      unique case (act_i)
        ACT_TOGGLE: oc_o <= ~oc_o;
        ACT_CLEAR:  oc_o <= 1'b0;
        ACT_SET:    oc_o <= 1'b1;
        default:    oc_o <= oc_o;
      endcase
    end
  end
endmodule

// File: rtl/pin_src_mux.sv
module pin_src_mux
  import cmp_pin_pkg::*;
(
  input  logic              oc_i,
  input  logic [MODE_W-1:0] act_mode_i,
  input  logic              port_data_i,
  input  logic              port_dir_i,
  output logic              pin_o,
  output logic              pin_oe_o
);
  // override selects data only; direction always stays with the port
  assign pin_o    = (|act_mode_i) ? oc_i : port_data_i;
  assign pin_oe_o = port_dir_i;
endmodule

// File: rtl/cmp_pin_unit.sv
module cmp_pin_unit
  import cmp_pin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              match_i,
  input  logic              force_i,
  input  logic              bottom_i,
  input  logic              count_down_i,
  input  logic [MODE_W-1:0] act_mode_i,
  input  logic [CLS_W-1:0]  wave_cls_i,
  input  logic              port_data_i,
  input  logic              port_dir_i,
  output logic              pin_o,
  output logic              pin_oe_o
);
  oc_act_e act;
  logic    oc_q;

  oc_event_dec i_dec (
    .match_i      (match_i),
    .force_i      (force_i),
    .bottom_i     (bottom_i),
    .count_down_i (count_down_i),
    .act_mode_i   (act_mode_i),
    .wave_cls_i   (wave_cls_i),
    .act_o        (act)
  );

  oc_state_reg i_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .oc_o   (oc_q)
  );

  pin_src_mux i_mux (
    .oc_i        (oc_q),
    .act_mode_i  (act_mode_i),
    .port_data_i (port_data_i),
    .port_dir_i  (port_dir_i),
    .pin_o       (pin_o),
    .pin_oe_o    (pin_oe_o)
  );
endmodule

// File: rtl/cmp_pin_unit_chk.sv
module cmp_pin_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       match_i,
  input logic       force_i,
  input logic       bottom_i,
  input logic [1:0] act_mode_i,
  input logic [1:0] wave_cls_i,
  input logic       oc_q,
  input logic       pin_o
);
  p_reset_clear_r1: assert property (@(posedge clk_i) !rst_ni |-> !oc_q);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode_i == 2'b00) |=> $stable(oc_q));

  p_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_cls_i == 2'b00 && act_mode_i == 2'b01 && match_i) |=> (oc_q != $past(oc_q)));

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_cls_i == 2'b00 && act_mode_i == 2'b11 && (match_i || force_i)) |=> oc_q);

  p_force_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_cls_i != 2'b00 && force_i && !match_i && !bottom_i) |=> $stable(oc_q));

  p_reserved_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_cls_i == 2'b11) |=> $stable(oc_q));

  p_pin_follows_oc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode_i != 2'b00) |-> (pin_o == oc_q));
endmodule

bind cmp_pin_unit cmp_pin_unit_chk i_cmp_pin_unit_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .match_i    (match_i),
  .force_i    (force_i),
  .bottom_i   (bottom_i),
  .act_mode_i (act_mode_i),
  .wave_cls_i (wave_cls_i),
  .oc_q       (oc_q),
  .pin_o      (pin_o)
);

// File: tb/test_cmp_pin_unit.sv
`timescale 1ns/1ps
module test_cmp_pin_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       match_i = 1'b0, force_i = 1'b0, bottom_i = 1'b0, count_down_i = 1'b0;
  logic [1:0] act_mode_i = 2'b00, wave_cls_i = 2'b00;
  logic       port_data_i = 1'b0, port_dir_i = 1'b0;
  logic       pin_o, pin_oe_o;

  int checks = 0;
  int fails  = 0;
  bit exp_oc = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  cmp_pin_unit i_cmp_pin_unit (.*);

  // reference: state after one edge, given the inputs held during it
  function automatic bit ref_next(bit cur, int cls, int mode, bit m, bit f, bit b, bit d);
    if (mode == 0) return cur;
    if (cls == 0) begin
      if (!(m || f)) return cur;
      if (mode == 1) return !cur;
      return (mode == 3);
    end
    if (cls == 1) begin
      if (mode == 1) return cur;
      if (m) return (mode == 3);
      if (b) return (mode == 2);
      return cur;
    end
    if (cls == 2) begin
      if (mode == 1 || !m) return cur;
      return (mode == 2) ? d : !d;
    end
    return cur;
  endfunction

  task automatic check(input string tag, input logic act, input logic expv, input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, expv);
    end
  endtask

  task automatic step(input int cls, input int mode, input bit m, input bit f, input bit b,
                      input bit d, input bit pd, input bit dir, input string tag);
    wave_cls_i = 2'(cls); act_mode_i = 2'(mode);
    match_i = m; force_i = f; bottom_i = b; count_down_i = d;
    port_data_i = pd; port_dir_i = dir;
    @(posedge clk_i);
    exp_oc = ref_next(exp_oc, cls, mode, m, f, b, d);
    #1;
    match_i = 1'b0; force_i = 1'b0; bottom_i = 1'b0;
    check(tag, pin_o, (mode != 0) ? exp_oc : pd, "pin_o");
    check(tag, pin_oe_o, dir, "pin_oe_o");
  endtask

  // peek at state through pin with mode 11, no strobe
  task automatic peek(input string tag);
    step(3, 3, 0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    act_mode_i = 2'b11; port_dir_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    check("R1", pin_o, 1'b0, "pin_o in reset");
    check("R1", pin_oe_o, 1'b1, "pin_oe_o in reset");
    @(negedge clk_i); rst_ni = 1'b1;
    peek("R1");

    // R3 non-PWM match actions
    step(0, 3, 1, 0, 0, 0, 0, 1, "R3");
    step(0, 2, 1, 0, 0, 0, 0, 1, "R3");
    step(0, 1, 1, 0, 0, 0, 0, 1, "R3");
    step(0, 1, 1, 0, 0, 0, 0, 1, "R3");
    step(0, 1, 0, 0, 0, 0, 0, 1, "R3");
    // R4 force in non-PWM
    step(0, 3, 0, 1, 0, 0, 0, 1, "R4");
    step(0, 1, 0, 1, 0, 0, 0, 1, "R4");
    step(0, 3, 0, 1, 0, 0, 0, 1, "R4");
    // R2 mode 00 freezes state; R8 pin shows port data
    step(0, 0, 1, 0, 0, 0, 0, 1, "R2");
    step(0, 0, 0, 1, 0, 0, 1, 1, "R8");
    step(1, 0, 1, 0, 1, 0, 0, 1, "R2");
    step(2, 0, 1, 0, 0, 1, 1, 1, "R2");
    peek("R2");
    // R5 force ignored in PWM classes
    step(1, 2, 0, 1, 0, 0, 0, 1, "R5");
    step(2, 2, 0, 1, 0, 1, 0, 1, "R5");
    step(1, 1, 0, 1, 0, 0, 0, 1, "R5");
    // R6 fast PWM
    step(1, 2, 1, 0, 0, 0, 0, 1, "R6");
    step(1, 2, 0, 0, 1, 0, 0, 1, "R6");
    step(1, 3, 1, 0, 0, 0, 0, 1, "R6");
    step(1, 3, 0, 0, 1, 0, 0, 1, "R6");
    step(1, 1, 1, 0, 0, 0, 0, 1, "R6");
    step(1, 1, 0, 0, 1, 0, 0, 1, "R6");
    step(1, 3, 0, 0, 1, 0, 0, 1, "R6");
    step(1, 1, 1, 0, 1, 0, 0, 1, "R6");
    // R10 coincident match and bottom, reserved class
    step(1, 3, 1, 0, 1, 0, 0, 1, "R10");
    step(1, 2, 1, 0, 1, 0, 0, 1, "R10");
    step(1, 3, 1, 0, 1, 0, 0, 1, "R10");
    step(3, 1, 1, 1, 1, 0, 0, 1, "R10");
    step(3, 2, 1, 1, 1, 1, 0, 1, "R10");
    // R7 phase-correct
    step(2, 2, 1, 0, 0, 0, 0, 1, "R7");
    step(2, 2, 1, 0, 0, 1, 0, 1, "R7");
    step(2, 3, 1, 0, 0, 1, 0, 1, "R7");
    step(2, 3, 1, 0, 0, 0, 0, 1, "R7");
    step(2, 1, 1, 0, 0, 1, 0, 1, "R7");
    step(2, 2, 0, 0, 1, 1, 0, 1, "R7");
    // R9 direction independent of mode
    step(0, 3, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 0, "R9");
    step(0, 2, 0, 0, 0, 0, 1, 1, "R9");
    // R11 preset while input, then enable
    step(0, 2, 0, 1, 0, 0, 0, 0, "R11");
    step(0, 3, 0, 1, 0, 0, 0, 0, "R11");
    step(0, 3, 0, 0, 0, 0, 0, 1, "R11");
    step(0, 2, 0, 1, 0, 0, 1, 0, "R11");
    step(0, 2, 0, 0, 0, 0, 1, 1, "R11");
    // mixed sweep
    for (int i = 0; i < 64; i++)
      step(i % 4, (i / 4) % 4, i[0], i[1], i[2], i[3], i[4], 1'b1, "R3");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule